// File: doc/BRIEF.md
# Triple-Channel Watchdog Register Block

This peripheral holds three independent 16-bit watchdog down-counters behind one small register window. Software gives each channel a countdown length in tenths of a second by writing its limit register. That write loads the counter and starts it. Software keeps the channel alive by reading its live-count register, which reloads the counter from the limit. The counter steps down once for each pulse on a tick input, which an external prescaler supplies. The prescaler is outside this block.

When a channel reaches zero it stops and raises its expired flag. The consequence depends on the channel. Channel 0 feeds an interrupt line, which a shared mask register can gate. Channel 1 issues a one-cycle processor reset pulse. Channel 2 issues a one-cycle reset pulse for the whole board. The two reset pulses cannot be masked. The expired flag, and any interrupt it causes, stays set until the limit register is written again.

Sixteen-bit registers travel over the bus with their two bytes exchanged. Byte-wide registers use the low data lane.

Top module: `wdt_trio`

## Requirements
- R1: After reset, every channel's live count and limit both hold 1. All status bytes are 0 and the mask is 0. The irq, cpu_rst and sys_rst outputs are low.
- R2: A halfword write to a channel's limit register sets the limit and the count to the written value. It also sets running (status bit 0) and clears expired (status bit 1), starting from the next cycle.
- R3: A running channel's count drops by one on each cycle in which tick is high. Without a tick, or while the channel is not running, the count does not change.
- R4: A read of the live-count register returns the current count. The count is then reloaded from the limit, unless the channel has expired. A read of the limit register changes nothing.
- R5: A tick that arrives while a running channel's count is 1 or 0 drives the count to 0, clears running and sets expired. Further ticks leave the count at 0.
- R6: The status byte carries running in bit 0 and expired in bit 1, and bits 7..2 read 0. The device status register at 0x34 always reads 0.
- R7: The mask register at 0x30 is written with a byte write and uses bits 2..0, one per channel. A 1 in a bit blocks that channel's interrupt. Bits 7..3 read 0. The irq output is high while any expired channel has a 0 in its mask bit.
- R8: An expiry of channel 1 pulses cpu_rst high for exactly one cycle, and an expiry of channel 2 pulses sys_rst the same way. The mask has no effect on either pulse. An expiry of channel 0 drives neither output.
- R9: Halfword registers appear on the bus byte-swapped: register bits 7..0 sit on data bits 15..8, and register bits 15..8 sit on data bits 7..0. This holds for both reads and writes.
- R10: Channel n occupies addresses 16*n to 16*n+15, with the live count at offset 0, the limit at offset 4 and the status at offset 8. Reads of any other address return 0.
- R11: The expired flag stays set, and the count stays at 0, until the channel's limit register is written again. Reads of the live-count register while the flag is set leave both unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle tenth-of-a-second pulse from the prescaler |
| bus_addr | input | 6 | Byte address within the register window |
| bus_wr_hw | input | 1 | Halfword write strobe |
| bus_wr_b | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Read strobe; its side effect happens at the clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, a combinational function of the address and the current state |
| irq | output | 1 | Interrupt from unmasked expired channels |
| cpu_rst | output | 1 | Processor reset pulse from channel 1 |
| sys_rst | output | 1 | Board reset pulse from channel 2 |

## Verification
The assertions assume that at most one strobe (read, halfword write or byte write) is active in any cycle. They also assume that tick lasts one cycle at a time.

The bench follows both rules. A bus task raises a single strobe for exactly one clock. The tick task pulses tick for one cycle with all strobes low, so a reload and a decrement never meet.

The limit sweep covers every channel with small lengths, including the limit-equals-one boundary. It rewrites each channel's limit with a large value before moving on, so only the channel under test can expire while the shared tick runs.

// File: rtl/wdt_trio_pkg.sv
// Shared constants and helpers for the triple watchdog block.
// Assumes a 6-bit byte address: bits 5..4 select a block, bits 3..0 the offset.
package wdt_trio_pkg;
    localparam int CH_N   = 3;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 16;
    localparam int MASK_W = CH_N;

    localparam logic [3:0] OFF_CNT = 4'h0;
    localparam logic [3:0] OFF_LIM = 4'h4;
    localparam logic [3:0] OFF_STS = 4'h8;
    localparam logic [1:0] BLK_CTL = 2'd3;   // block holding the mask and device status

    // Exchange the two bytes of a halfword (the same for the read and write directions).
    function automatic logic [DATA_W-1:0] swap16(input logic [DATA_W-1:0] v);
        return {v[7:0], v[15:8]};
    endfunction
endpackage

// File: rtl/wdt_chan.sv
// One watchdog channel: limit register, down-counter, running/expired flags
// and a one-cycle expiry pulse. Assumes ld_en and svc are never high together.
module wdt_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ld_en,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             svc,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] lim,
    output logic             run,
    output logic             exp,
    output logic             fire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Counter state update: a load beats a service, and a service beats a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= ONE;
            lim  <= ONE;
            run  <= 1'b0;
            exp  <= 1'b0;
            fire <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (ld_en) begin
                lim <= ld_val;
                cnt <= ld_val;
                run <= 1'b1;
                exp <= 1'b0;
            end else if (svc && !exp) begin
                cnt <= lim;
            end else if (tick && run) begin
                if (cnt <= ONE) begin
                    cnt  <= '0;
                    run  <= 1'b0;
                    exp  <= 1'b1;
                    fire <= 1'b1;
                end else begin
                    cnt <= cnt - ONE;
                end
            end
        end
    end

    // R2
    load_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (run && !exp && cnt == $past(ld_val)));
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !svc && !ld_en) |=> $stable(cnt));
    // R5
    expired_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exp |-> (cnt == '0 && !run));
    // R11
    expired_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exp && !ld_en) |=> exp);
    // R8
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
endmodule

// File: rtl/wdt_regdec.sv
// Register decoder: turns bus strobes into per-channel load/service requests,
// mask writes and the combinational read mux. Assumes one strobe per cycle.
module wdt_regdec
    import wdt_trio_pkg::*;
(
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       wr_hw,
    input  logic                       wr_b,
    input  logic                       rd,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [CH_N-1:0][CNT_W-1:0] cnt_all,
    input  logic [CH_N-1:0][CNT_W-1:0] lim_all,
    input  logic [CH_N-1:0]            run_all,
    input  logic [CH_N-1:0]            exp_all,
    input  logic [MASK_W-1:0]          mask,
    output logic [CH_N-1:0]            ld_en,
    output logic [CNT_W-1:0]           ld_val,
    output logic [CH_N-1:0]            svc,
    output logic                       mask_we,
    output logic [MASK_W-1:0]          mask_val,
    output logic [DATA_W-1:0]          rdata
);
    logic [1:0] blk;
    logic [3:0] off;

    assign blk      = addr[5:4];
    assign off      = addr[3:0];
    assign ld_val   = swap16(wdata);
    assign mask_we  = wr_b && blk == BLK_CTL && off == OFF_CNT;
    assign mask_val = wdata[MASK_W-1:0];

    // Per-channel strobes for a limit write and a live-count read.
    always_comb begin
        for (int i = 0; i < CH_N; i++) begin
            ld_en[i] = wr_hw && blk == 2'(i) && off == OFF_LIM;
            svc[i]   = rd    && blk == 2'(i) && off == OFF_CNT;
        end
    end

    // Read mux over the channel blocks and the control block.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < CH_N; i++) begin
            if (blk == 2'(i)) begin
                case (off)
                    OFF_CNT: rdata = swap16(cnt_all[i]);
                    OFF_LIM: rdata = swap16(lim_all[i]);
                    OFF_STS: rdata = {14'd0, exp_all[i], run_all[i]};
                    default: rdata = '0;
                endcase
            end
        end
        if (blk == BLK_CTL && off == OFF_CNT)
            rdata = {{(DATA_W-MASK_W){1'b0}}, mask};
    end
endmodule

// File: rtl/wdt_trio.sv
// Top of the triple watchdog: three channels, the shared interrupt mask,
// the interrupt OR and the two reset pulses. Assumes tick is one cycle wide.
module wdt_trio
    import wdt_trio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_hw,
    input  logic              bus_wr_b,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              cpu_rst,
    output logic              sys_rst
);
    logic [CH_N-1:0][CNT_W-1:0] cnt_all;
    logic [CH_N-1:0][CNT_W-1:0] lim_all;
    logic [CH_N-1:0]            run_all;
    logic [CH_N-1:0]            exp_all;
    logic [CH_N-1:0]            fire_all;
    logic [CH_N-1:0]            ld_en;
    logic [CH_N-1:0]            svc;
    logic [CNT_W-1:0]           ld_val;
    logic                       mask_we;
    logic [MASK_W-1:0]          mask_val;
    logic [MASK_W-1:0]          mask_q;

    wdt_regdec u_dec (
        .addr    (bus_addr),
        .wr_hw   (bus_wr_hw),
        .wr_b    (bus_wr_b),
        .rd      (bus_rd),
        .wdata   (bus_wdata),
        .cnt_all (cnt_all),
        .lim_all (lim_all),
        .run_all (run_all),
        .exp_all (exp_all),
        .mask    (mask_q),
        .ld_en   (ld_en),
        .ld_val  (ld_val),
        .svc     (svc),
        .mask_we (mask_we),
        .mask_val(mask_val),
        .rdata   (bus_rdata)
    );

    for (genvar g = 0; g < CH_N; g++) begin : g_ch
        wdt_chan #(.CNT_W(CNT_W)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .ld_en (ld_en[g]),
            .ld_val(ld_val),
            .svc   (svc[g]),
            .cnt   (cnt_all[g]),
            .lim   (lim_all[g]),
            .run   (run_all[g]),
            .exp   (exp_all[g]),
            .fire  (fire_all[g])
        );
    end

    // Shared interrupt mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_val;
    end

    assign irq     = |(exp_all & ~mask_q);
    assign cpu_rst = fire_all[1];
    assign sys_rst = fire_all[2];

    // R7
    full_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |-> !irq);
    // R8
    cpu_rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst |-> exp_all[1]);
endmodule

// File: tb/tb_wdt_trio.sv
module tb_wdt_trio;
    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr_hw = 1'b0;
    logic        bus_wr_b = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq, cpu_rst, sys_rst;

    int total = 0;
    int bad = 0;
    logic [15:0] rv;

    always #(CLK_PER/2) clk = ~clk;

    wdt_trio dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
        .bus_wr_hw(bus_wr_hw), .bus_wr_b(bus_wr_b), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .cpu_rst(cpu_rst), .sys_rst(sys_rst)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] expv, input string tag);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [15:0] sw(input logic [15:0] v);
        return {v[7:0], v[15:8]};
    endfunction

    // Halfword write of register value v (swapped onto the bus).
    task automatic wr_hw(input logic [5:0] a, input logic [15:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = sw(v); bus_wr_hw = 1'b1;
        @(posedge clk); #1;
        bus_wr_hw = 1'b0;
    endtask

    task automatic wr_b(input logic [5:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = {8'h00, v}; bus_wr_b = 1'b1;
        @(posedge clk); #1;
        bus_wr_b = 1'b0;
    endtask

    // Raw bus read; the value is captured before the clock edge takes effect.
    task automatic rd(input logic [5:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(posedge clk); #1;
        tick = 1'b0;
    endtask

    initial begin
        #(CLK_PER * 100000);
        bad++; total++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 / R9 / R10 / R6: reset state of every block
        for (int c = 0; c < 3; c++) begin
            rd(6'(16*c + 4), rv); chk(rv, 16'h0100, "R1 R9 limit after reset");
            rd(6'(16*c),     rv); chk(rv, 16'h0100, "R1 count after reset");
            rd(6'(16*c + 8), rv); chk(rv, 16'h0000, "R1 R6 status after reset");
        end
        rd(6'h30, rv); chk(rv, 16'h0000, "R1 mask after reset");
        rd(6'h34, rv); chk(rv, 16'h0000, "R6 device status zero");
        rd(6'h0C, rv); chk(rv, 16'h0000, "R10 unused offset reads zero");
        chk({13'd0, irq, cpu_rst, sys_rst}, 16'h0, "R1 outputs low");

        // R3: idle channels ignore ticks
        pulse_tick(); pulse_tick();
        rd(6'h14, rv); chk(rv, 16'h0100, "R3 idle channel ignores tick (limit)");
        rd(6'h10, rv); chk(rv, 16'h0100, "R3 idle channel ignores tick (count)");

        // R9: byte order with an asymmetric value
        wr_hw(6'h04, 16'h1234);
        rd(6'h04, rv); chk(rv, 16'h3412, "R9 swapped limit readback");
        wr_hw(6'h04, 16'hFFFF);

        // Sweep: every channel, limits 1..4, mask pattern varies
        for (int c = 0; c < 3; c++) begin
            for (int L = 1; L <= 4; L++) begin
                logic [2:0] m;
                m = 3'((c * 4 + L) % 8);
                wr_b(6'h30, {5'd0, m});
                wr_hw(6'(16*c + 4), 16'(L));
                rd(6'(16*c + 8), rv); chk(rv, 16'h0001, "R2 running after limit write");
                // R3 / R4: tick L-1 times, read live count, then read again
                for (int k = 0; k < L - 1; k++) pulse_tick();
                rd(6'(16*c + 4), rv); chk(sw(rv), 16'(L), "R4 limit read value");
                rd(6'(16*c), rv); chk(sw(rv), 16'(1), "R3 count after ticks");
                rd(6'(16*c), rv); chk(sw(rv), 16'(L), "R4 count reloaded by read");
                // Run down from L to expiry
                for (int k = 0; k < L - 1; k++) pulse_tick();
                chk({15'd0, irq}, 16'h0, "R5 not yet expired");
                pulse_tick();
                chk({15'd0, cpu_rst}, 16'(c == 1), "R8 cpu_rst pulse");
                chk({15'd0, sys_rst}, 16'(c == 2), "R8 sys_rst pulse");
                @(posedge clk); #1;
                chk({14'd0, cpu_rst, sys_rst}, 16'h0, "R8 pulse lasts one cycle");
                chk({15'd0, irq}, 16'(!m[c]), "R7 irq versus mask");
                rd(6'(16*c + 8), rv); chk(rv, 16'h0002, "R5 R6 expired status");
                pulse_tick();
                rd(6'(16*c), rv); chk(rv, 16'h0000, "R5 R11 count held at zero");
                rd(6'(16*c + 8), rv); chk(rv, 16'h0002, "R11 expired sticky after read");
                wr_hw(6'(16*c + 4), 16'hFFFF);
                rd(6'(16*c + 8), rv); chk(rv, 16'h0001, "R2 R11 rewrite clears expired");
            end
        end

        // R7: mask upper bits read zero
        wr_b(6'h30, 8'hFF);
        rd(6'h30, rv); chk(rv, 16'h0007, "R7 mask upper bits zero");

        // R7 / R8: all three expire together, full mask does not block resets
        for (int c = 0; c < 3; c++) wr_hw(6'(16*c + 4), 16'h0001);
        pulse_tick();
        chk({14'd0, cpu_rst, sys_rst}, 16'h0003, "R8 resets unmasked");
        chk({15'd0, irq}, 16'h0, "R7 all masked irq low");
        for (int m = 0; m < 8; m++) begin
            wr_b(6'h30, 8'(m));
            chk({15'd0, irq}, 16'(m != 7), "R7 mask sweep");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule